// File: doc/BRIEF.md
# Line Timing and Sandcastle Pulse Generator

This block turns a line-locked sample clock and a line-start strobe into the per-line timing pulses that a picture-in-picture video path needs. These are a horizontal sync pulse, a burst-key pulse, a line-blanking pulse and a vertical-blanking flag. It also produces the three output-enable controls of a composite sandcastle pin. The pin is pulled low during active scan and pulled high during burst key. In all other blanked time it is released to high impedance. Analog levels and the line oscillator are outside the block.

All horizontal timing comes from a phase counter that runs on the sample clock. A line-start strobe forces the phase to zero in the same cycle it arrives, so the horizontal pulse leads with no delay. When no strobe arrives, the counter wraps at the nominal line period, so the pulses never stop. Pulse widths are given as nanosecond parameters and converted to whole ticks as `CLK_MHZ * ns / 1000`, rounded down. A vertical-start strobe opens a vertical-blanking interval that lasts a parameterised number of lines, 14 by default.

Top module: `lt_sandcastle_gen`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, the signals hsync_o, burst_key_o, line_blank_o, vblank_o, sc_drive_low_o and sc_drive_high_o are 0 and sc_float_o is 1. Strobes are ignored during this time.
- R2: hsync_o is 1 exactly when the line phase is below HS_T = CLK_MHZ*HS_NS/1000 ticks. It is therefore 1 in the same cycle that line_start is high.
- R3: line_blank_o is 1 exactly when the line phase is below LB_T = CLK_MHZ*LB_NS/1000 ticks.
- R4: burst_key_o is 1 exactly when the phase lies in [BK_OFS_T, BK_OFS_T+BK_T). Here BK_OFS_T = CLK_MHZ*BK_OFS_NS/1000 and BK_T = CLK_MHZ*BK_NS/1000. The burst key lies inside line blanking.
- R5: With no line_start, the phase increments by one per cycle and wraps from LINE_T-1 to 0, where LINE_T = CLK_MHZ*LINE_NS/1000. The first running cycle after reset release has phase 0.
- R6: A line_start strobe at any phase sets the phase to 0 in that cycle. Counting continues from 0 in the following cycles.
- R7: vblank_o is 1 from the cycle in which vert_start is high. It stays 1 until the VB_LINES-th later line start (phase 0), at which it is 0. The line holding the strobe counts as the first blanked line. A new vert_start while vblank_o is 1 restarts the count.
- R8: Exactly one of sc_drive_low_o, sc_drive_high_o and sc_float_o is 1 in every cycle. When running, sc_drive_high_o is 1 when burst_key_o is 1, including during vertical blanking. Otherwise sc_float_o is 1 when line_blank_o or vblank_o is 1. Otherwise sc_drive_low_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the leading edge of incoming line sync |
| vert_start | input | 1 | One-cycle strobe at the start of vertical sync |
| hsync_o | output | 1 | Horizontal sync output pulse |
| burst_key_o | output | 1 | Burst-key pulse |
| line_blank_o | output | 1 | Line-blanking pulse |
| vblank_o | output | 1 | Vertical-blanking flag |
| sc_drive_low_o | output | 1 | Sandcastle pin: actively pull low (scan) |
| sc_drive_high_o | output | 1 | Sandcastle pin: actively pull high (burst key) |
| sc_float_o | output | 1 | Sandcastle pin: release to high impedance (blanking) |

## Verification
The bench builds the block with CLK_MHZ = 1 and the default nanosecond values. This gives a 64-tick line with a 5-tick sync pulse, an 8-tick blank and a 3-tick burst key at ticks 5 to 7. The burst key therefore ends exactly on the last blanked tick. At this size, a restart strobe can be issued at every phase of the line, including the wrap point. Complete 14-line vertical intervals also fit easily in the run, and they can be started on a line boundary, in mid-line, or reloaded while already active. Every output is compared against an arithmetic model of the phase in every cycle.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [1:0] {
    SC_LOW   = 2'd0,
    SC_HIGH  = 2'd1,
    SC_FLOAT = 2'd2
  } sc_state_e;

  localparam int unsigned NUM_WIN = 3;
  localparam int unsigned WIN_HS  = 0;
  localparam int unsigned WIN_BK  = 1;
  localparam int unsigned WIN_LB  = 2;

  function automatic int unsigned ns_to_ticks(input int unsigned mhz, input int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

endpackage

// File: rtl/lt_phase_counter.sv
module lt_phase_counter #(
  parameter int unsigned LINE_TICKS = 1728,
  parameter int unsigned PW         = $clog2(LINE_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_start,
  output logic [PW-1:0] phase,
  output logic          line_begin
);

  localparam logic [PW-1:0] LAST = PW'(LINE_TICKS - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic [PW-1:0] phase_c;

  // next-state: phase of the current cycle, zero on a strobe or wrap
  always_comb begin
    if (line_start || (cnt_q == LAST)) begin
      phase_c = '0;
    end else begin
      phase_c = cnt_q + 1'b1;
    end
    cnt_d = run ? phase_c : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign phase      = run ? phase_c : '0;
  assign line_begin = run && (phase_c == '0);

  AST_RESTART_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_start) |=> (line_start || phase == PW'(1))); // R6

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !line_start && $past(phase) == LAST) |-> line_begin); // R5

endmodule

// File: rtl/lt_window.sv
module lt_window #(
  parameter int unsigned PW    = 11,
  parameter int unsigned START = 0,
  parameter int unsigned LEN   = 1
) (
  input  logic          run,
  input  logic [PW-1:0] phase,
  output logic          active
);

  localparam logic [PW:0] END_V = (PW+1)'(START + LEN);

  logic lo_ok;
  logic hi_ok;

  generate
    if (START == 0) begin : g_from_zero
      assign lo_ok = 1'b1;
    end else begin : g_from_ofs
      assign lo_ok = ({1'b0, phase} >= (PW+1)'(START));
    end
  endgenerate

  assign hi_ok  = ({1'b0, phase} < END_V);
  assign active = run && lo_ok && hi_ok;

endmodule

// File: rtl/lt_vblank.sv
module lt_vblank #(
  parameter int unsigned VB_LINES = 14,
  parameter int unsigned VW       = $clog2(VB_LINES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic vert_start,
  input  logic line_begin,
  output logic vblank
);

  localparam logic [VW-1:0] LOAD = VW'(VB_LINES);
  localparam logic [VW-1:0] ONE  = VW'(1);

  logic [VW-1:0] rem_q;
  logic [VW-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (run) begin
      if (vert_start) begin
        rem_d = LOAD;
      end else if (line_begin && (rem_q != '0)) begin
        rem_d = rem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

  assign vblank = run && (vert_start || (rem_q > ONE) || ((rem_q == ONE) && !line_begin));

  AST_VB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && vert_start) |-> vblank); // R7

  AST_VB_CLOSE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(vblank)) |-> line_begin); // R7

endmodule

// File: rtl/lt_sandcastle_gen.sv
module lt_sandcastle_gen #(
  parameter int unsigned CLK_MHZ   = 27,
  parameter int unsigned LINE_NS   = 64000,
  parameter int unsigned HS_NS     = 5400,
  parameter int unsigned BK_NS     = 3500,
  parameter int unsigned BK_OFS_NS = 5000,
  parameter int unsigned LB_NS     = 8700,
  parameter int unsigned VB_LINES  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic vert_start,
  output logic hsync_o,
  output logic burst_key_o,
  output logic line_blank_o,
  output logic vblank_o,
  output logic sc_drive_low_o,
  output logic sc_drive_high_o,
  output logic sc_float_o
);
  import lt_pkg::*;

  localparam int unsigned LINE_T   = ns_to_ticks(CLK_MHZ, LINE_NS);
  localparam int unsigned HS_T     = ns_to_ticks(CLK_MHZ, HS_NS);
  localparam int unsigned BK_T     = ns_to_ticks(CLK_MHZ, BK_NS);
  localparam int unsigned BK_OFS_T = ns_to_ticks(CLK_MHZ, BK_OFS_NS);
  localparam int unsigned LB_T     = ns_to_ticks(CLK_MHZ, LB_NS);
  localparam int unsigned PW       = $clog2(LINE_T);

  localparam int unsigned WIN_START [NUM_WIN] = '{0, BK_OFS_T, 0};
  localparam int unsigned WIN_LEN   [NUM_WIN] = '{HS_T, BK_T, LB_T};

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign run = rs_q[1];

  logic [PW-1:0]      phase;
  logic               line_begin;
  logic [NUM_WIN-1:0] win_act;

  lt_phase_counter #(.LINE_TICKS(LINE_T), .PW(PW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .line_start (line_start),
    .phase      (phase),
    .line_begin (line_begin)
  );

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      lt_window #(.PW(PW), .START(WIN_START[g]), .LEN(WIN_LEN[g])) u_win (
        .run    (run),
        .phase  (phase),
        .active (win_act[g])
      );
    end
  endgenerate

  lt_vblank #(.VB_LINES(VB_LINES)) u_vb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .vert_start (vert_start),
    .line_begin (line_begin),
    .vblank     (vblank_o)
  );

  assign hsync_o      = win_act[WIN_HS];
  assign burst_key_o  = win_act[WIN_BK];
  assign line_blank_o = win_act[WIN_LB];

  sc_state_e sc_state;

  always_comb begin
    if (!run) begin
      sc_state = SC_FLOAT;
    end else if (burst_key_o) begin
      sc_state = SC_HIGH;
    end else if (line_blank_o || vblank_o) begin
      sc_state = SC_FLOAT;
    end else begin
      sc_state = SC_LOW;
    end
  end

  assign sc_drive_low_o  = (sc_state == SC_LOW);
  assign sc_drive_high_o = (sc_state == SC_HIGH);
  assign sc_float_o      = (sc_state == SC_FLOAT);

  AST_SC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sc_drive_low_o, sc_drive_high_o, sc_float_o})); // R8

  AST_BK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_key_o |-> sc_drive_high_o); // R8

  AST_SCAN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_blank_o && !vblank_o && !burst_key_o) |-> sc_drive_low_o); // R8

  AST_BK_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    burst_key_o |-> line_blank_o); // R4

  AST_HS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_start) |-> hsync_o); // R2

endmodule

// File: tb/lt_sandcastle_gen_test.sv
module lt_sandcastle_gen_test;

  localparam int CLK_MHZ = 1;
  localparam int LINE    = CLK_MHZ * 64000 / 1000;
  localparam int HS      = CLK_MHZ * 5400 / 1000;
  localparam int BK      = CLK_MHZ * 3500 / 1000;
  localparam int BKO     = CLK_MHZ * 5000 / 1000;
  localparam int LB      = CLK_MHZ * 8700 / 1000;
  localparam int VBL     = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic line_start;
  logic vert_start;
  logic hsync_o, burst_key_o, line_blank_o, vblank_o;
  logic sc_drive_low_o, sc_drive_high_o, sc_float_o;

  always #5 clk = ~clk;

  lt_sandcastle_gen #(.CLK_MHZ(CLK_MHZ), .VB_LINES(VBL)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .line_start      (line_start),
    .vert_start      (vert_start),
    .hsync_o         (hsync_o),
    .burst_key_o     (burst_key_o),
    .line_blank_o    (line_blank_o),
    .vblank_o        (vblank_o),
    .sc_drive_low_o  (sc_drive_low_o),
    .sc_drive_high_o (sc_drive_high_o),
    .sc_float_o      (sc_float_o)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  int m_phase = 0;
  bit vb_act  = 0;
  int vb_lines = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (model phase %0d)", tag, act, exp, m_phase);
    end
  endtask

  // one running cycle: drive, advance the model, compare before the next edge
  task automatic step(input logic ls, input logic vs);
    logic e_hs, e_bk, e_lb, e_vb;
    @(posedge clk);
    #1;
    line_start = ls;
    vert_start = vs;
    m_phase = ls ? 0 : ((m_phase == LINE - 1) ? 0 : m_phase + 1);
    if (vs) begin
      vb_act = 1;
      vb_lines = 0;
    end else if (vb_act && m_phase == 0) begin
      vb_lines++;
      if (vb_lines >= VBL) vb_act = 0;
    end
    e_hs = (m_phase < HS);
    e_bk = (m_phase >= BKO) && (m_phase < BKO + BK);
    e_lb = (m_phase < LB);
    e_vb = vb_act;
    #3;
    chk("R2,R5,R6 hsync", hsync_o, e_hs);
    chk("R4 burst_key", burst_key_o, e_bk);
    chk("R3 line_blank", line_blank_o, e_lb);
    chk("R7 vblank", vblank_o, e_vb);
    chk("R8 drive_high", sc_drive_high_o, e_bk);
    chk("R8 float", sc_float_o, !e_bk && (e_lb || e_vb));
    chk("R8 drive_low", sc_drive_low_o, !e_bk && !e_lb && !e_vb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    line_start = 1'b1;
    vert_start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #4;
      // R1: reset state with strobes held high
      chk("R1 hsync", hsync_o, 1'b0);
      chk("R1 burst_key", burst_key_o, 1'b0);
      chk("R1 line_blank", line_blank_o, 1'b0);
      chk("R1 vblank", vblank_o, 1'b0);
      chk("R1 drive_low", sc_drive_low_o, 1'b0);
      chk("R1 drive_high", sc_drive_high_o, 1'b0);
      chk("R1 float", sc_float_o, 1'b1);
    end
    line_start = 1'b0;
    vert_start = 1'b0;
    rst_n = 1'b1;
    // first edge after release: synchronizer still holds the block idle (R1)
    @(posedge clk);
    #4;
    chk("R1 float after release", sc_float_o, 1'b1);
    chk("R1 hsync after release", hsync_o, 1'b0);
    // second edge releases; the first running cycle has phase 0 (R5)
    m_phase = LINE - 1;
    step(1'b0, 1'b0);
    idle(LINE + 7);

    // align and free-run over several lines (R5)
    step(1'b1, 1'b0);
    idle(3 * LINE + 5);

    // restart at every phase of the line, wrap point included (R6)
    for (int k = 0; k <= LINE + 2; k++) begin
      step(1'b1, 1'b0);
      idle(k);
    end

    // vertical blanking on a line boundary (R7)
    step(1'b1, 1'b1);
    idle((VBL + 2) * LINE);

    // vertical start in mid-line, then reload while still active (R7)
    idle(30);
    step(1'b0, 1'b1);
    idle(5 * LINE + 11);
    step(1'b0, 1'b1);
    idle((VBL + 1) * LINE);

    // vertical start together with a mid-line restart, during burst key (R7, R8)
    idle(20);
    step(1'b1, 1'b0);
    idle(BKO - 1);
    step(1'b0, 1'b1);
    idle((VBL + 1) * LINE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule